// File: doc/BRIEF.md
# TFT Panel Colour Depth Reducer

This block takes a stream of 24-bit RGB pixels and reduces each colour component to 3 or 4 bits, so the pixels suit a thin-film-transistor panel with 9 or 12 data lines. The basic operation keeps only the top bits of each component.

Two optional stages can use the first bit that truncation drops to recover some of the lost intensity. The first is a 2x2 spatial dither. The second is a temporal frame-rate modulation stage. The frame-rate modulation stage can advance its pattern on every frame, or on every second frame for slow liquid crystal.

Each pixel carries the low bit of its x and y position. A separate frame-start pulse drives the temporal pattern. Static configuration inputs select:

- the depth,
- the enables for the two stages,
- the modulation rate,
- blanking of the lower part of the panel bus.

The result appears on an 18-bit panel bus one clock after the pixel is accepted.

Top module: `tft_depth_reducer`

## Requirements
- R1: With `cfg_depth_hi` = 0, each component is reduced to its top 3 bits. The component is placed in the low 3 bits of its 6-bit panel field, and the upper 3 bits of every field are 0. Fields: red in `out_panel[17:12]`, green in `[11:6]`, blue in `[5:0]`. Red, green and blue arrive in `in_rgb[23:16]`, `[15:8]` and `[7:0]`.
- R2: With `cfg_depth_hi` = 1, each component is reduced to its top 4 bits, placed in the low 4 bits of its field.
- R3: With `cfg_dither_en` = 0 and `cfg_frm_en` = 0, each field is exactly the truncated value.
- R4: With dither active and modulation off, the first dropped bit is added to the truncated value when `in_x0` XOR `in_y0` = 1. It is not added otherwise.
- R5: With `cfg_frm_en` = 1, the first dropped bit is added when phase XOR `in_x0` XOR `in_y0` = 1. The phase is 0 after reset.
- R6: With `cfg_frm_slow` = 0, the phase inverts on every frame-start pulse. A pixel accepted in the same cycle as the pulse still uses the old phase.
- R7: With `cfg_frm_slow` = 1, the phase inverts only on frame-start pulses that are even-numbered. The count runs over all pulses since reset (the 2nd, 4th and so on).
- R8: In 4-bit mode with modulation enabled, `cfg_dither_en` has no effect.
- R9: In 3-bit mode with both stages enabled, the dropped bit is added when either the dither condition or the modulation condition holds.
- R10: An addition never wraps. A field already at all ones (7 in 3-bit mode, 15 in 4-bit mode) stays at all ones.
- R11: With `cfg_lo_bus_en` = 0, `out_panel[8:0]` is driven to 0 for every accepted pixel.
- R12: `out_valid` equals `in_valid` delayed by one clock. `out_panel` changes only on the clock after an accepted pixel and otherwise holds.
- R13: While reset is asserted, `out_valid` and `out_panel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel accepted this cycle |
| in_rgb | input | 24 | Pixel, red in the top byte, blue in the bottom byte |
| in_x0 | input | 1 | Low bit of the pixel column |
| in_y0 | input | 1 | Low bit of the pixel row |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| cfg_depth_hi | input | 1 | 0: 3-bit components, 1: 4-bit components |
| cfg_dither_en | input | 1 | Enables the 2x2 spatial dither |
| cfg_frm_en | input | 1 | Enables frame-rate modulation |
| cfg_frm_slow | input | 1 | 0: phase advances every frame, 1: every second frame |
| cfg_lo_bus_en | input | 1 | 0: lower 9 panel bits forced to 0 |
| out_valid | output | 1 | Panel data valid |
| out_panel | output | 18 | Panel data bus |

## Verification
The bench builds the block with its default parameters: 8-bit components, 6-bit panel fields, depths of 3 and 4, and a 9-bit blanking region. At that size every one of the 32 configuration combinations can be swept, together with every value of each component.

In each configuration four frames pass, so the bench sees both phases of the temporal pattern and, in slow mode, the pairing of pulses. The bench also rotates the pixel position through all four x/y parities. This covers the saturation boundary, the point where dither is forced off, and the same-cycle rule for a frame pulse.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

  localparam int NUM_COMP = 3;

  typedef struct packed {
    logic depth_hi;
    logic dither_en;
    logic frm_en;
    logic frm_slow;
    logic lo_bus_en;
  } tdr_cfg_t;

endpackage

// File: rtl/tdr_frm_phase.sv
module tdr_frm_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start_i,
  input  logic slow_i,
  output logic phase_o
);

  logic pair_q, pair_d;
  logic phase_q, phase_d;
  logic advance;

  always_comb begin
    advance = frame_start_i & (~slow_i | pair_q);
    pair_d  = frame_start_i ? ~pair_q : pair_q;
    phase_d = advance ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q  <= 1'b0;
      phase_q <= 1'b0;
    end else if (frame_start_i) begin
      pair_q  <= pair_d;
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;

  // R6
  fast_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && !slow_i) |=> (phase_q != $past(phase_q)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start_i |=> $stable(phase_q));

endmodule

// File: rtl/tdr_comp_reduce.sv
module tdr_comp_reduce #(
  parameter int COMP_W   = 8,
  parameter int FIELD_W  = 6,
  parameter int LO_DEPTH = 3,
  parameter int HI_DEPTH = 4
) (
  input  logic [COMP_W-1:0]  comp_i,
  input  logic               depth_hi_i,
  input  logic               dith_act_i,
  input  logic               frm_act_i,
  input  logic               phase_i,
  input  logic               pos_i,
  output logic [FIELD_W-1:0] field_o
);

  localparam logic [HI_DEPTH-1:0] LO_MAX = HI_DEPTH'((1 << LO_DEPTH) - 1);
  localparam logic [HI_DEPTH-1:0] HI_MAX = '1;

  logic [HI_DEPTH-1:0] trunc, limit, level;
  logic                disc, bump;

  always_comb begin
    if (depth_hi_i) begin
      trunc = comp_i[COMP_W-1 -: HI_DEPTH];
      disc  = comp_i[COMP_W-1-HI_DEPTH];
      limit = HI_MAX;
    end else begin
      trunc = HI_DEPTH'(comp_i[COMP_W-1 -: LO_DEPTH]);
      disc  = comp_i[COMP_W-1-LO_DEPTH];
      limit = LO_MAX;
    end
    bump    = disc & ((dith_act_i & pos_i) | (frm_act_i & (phase_i ^ pos_i)));
    level   = (bump && (trunc != limit)) ? trunc + 1'b1 : trunc;
    field_o = FIELD_W'(level);
  end

endmodule

// File: rtl/tft_depth_reducer.sv
module tft_depth_reducer #(
  parameter int COMP_W   = 8,
  parameter int FIELD_W  = 6,
  parameter int LO_DEPTH = 3,
  parameter int HI_DEPTH = 4,
  parameter int BLANK_W  = 9
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  input  logic [tdr_pkg::NUM_COMP*COMP_W-1:0]  in_rgb,
  input  logic                                 in_x0,
  input  logic                                 in_y0,
  input  logic                                 frame_start,
  input  logic                                 cfg_depth_hi,
  input  logic                                 cfg_dither_en,
  input  logic                                 cfg_frm_en,
  input  logic                                 cfg_frm_slow,
  input  logic                                 cfg_lo_bus_en,
  output logic                                 out_valid,
  output logic [tdr_pkg::NUM_COMP*FIELD_W-1:0] out_panel
);
  import tdr_pkg::*;

  localparam int PANEL_W = NUM_COMP * FIELD_W;
  localparam logic [PANEL_W-1:0] BLANK_MASK = PANEL_W'((1 << BLANK_W) - 1);

  tdr_cfg_t cfg;
  logic     phase, pos, dith_act;
  logic [PANEL_W-1:0] raw_panel, panel_d, panel_q;
  logic     valid_d, valid_q;

  assign cfg = '{depth_hi: cfg_depth_hi, dither_en: cfg_dither_en,
                 frm_en: cfg_frm_en, frm_slow: cfg_frm_slow,
                 lo_bus_en: cfg_lo_bus_en};

  assign pos      = in_x0 ^ in_y0;
  assign dith_act = cfg.dither_en & ~(cfg.depth_hi & cfg.frm_en);

  tdr_frm_phase u_phase (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start),
    .slow_i        (cfg.frm_slow),
    .phase_o       (phase)
  );

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    tdr_comp_reduce #(
      .COMP_W   (COMP_W),
      .FIELD_W  (FIELD_W),
      .LO_DEPTH (LO_DEPTH),
      .HI_DEPTH (HI_DEPTH)
    ) u_reduce (
      .comp_i     (in_rgb[c*COMP_W +: COMP_W]),
      .depth_hi_i (cfg.depth_hi),
      .dith_act_i (dith_act),
      .frm_act_i  (cfg.frm_en),
      .phase_i    (phase),
      .pos_i      (pos),
      .field_o    (raw_panel[c*FIELD_W +: FIELD_W])
    );

    // R1
    lo_depth_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cfg_depth_hi) |=>
        (out_panel[c*FIELD_W+LO_DEPTH +: FIELD_W-LO_DEPTH] == '0));

    // R10
    saturate_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cfg_depth_hi && cfg_lo_bus_en &&
       (in_rgb[c*COMP_W+COMP_W-1 -: HI_DEPTH] == '1)) |=>
        (out_panel[c*FIELD_W +: HI_DEPTH] == '1));

    // R8
    no_dither_hi_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cfg_depth_hi && cfg_frm_en && cfg_lo_bus_en &&
       !(phase ^ in_x0 ^ in_y0)) |=>
        (out_panel[c*FIELD_W +: HI_DEPTH] ==
         $past(in_rgb[c*COMP_W+COMP_W-1 -: HI_DEPTH])));
  end

  always_comb begin
    valid_d = in_valid;
    panel_d = panel_q;
    if (in_valid) begin
      panel_d = cfg.lo_bus_en ? raw_panel : (raw_panel & ~BLANK_MASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      panel_q <= '0;
    end else begin
      valid_q <= valid_d;
      if (in_valid) begin
        panel_q <= panel_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_panel = panel_q;

  // R12
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R12
  panel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_panel));

  // R11
  blank_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_lo_bus_en) |=> (out_panel[BLANK_W-1:0] == '0));

endmodule

// File: tb/tft_depth_reducer_tb.sv
`timescale 1ns/1ps
module tft_depth_reducer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_rgb;
  logic        in_x0, in_y0, frame_start;
  logic        cfg_depth_hi, cfg_dither_en, cfg_frm_en, cfg_frm_slow, cfg_lo_bus_en;
  logic        out_valid;
  logic [17:0] out_panel;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  logic m_phase;
  logic m_pair;

  always #5 clk = ~clk;

  tft_depth_reducer #(
    .COMP_W(8), .FIELD_W(6), .LO_DEPTH(3), .HI_DEPTH(4), .BLANK_W(9)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rgb(in_rgb),
    .in_x0(in_x0), .in_y0(in_y0), .frame_start(frame_start),
    .cfg_depth_hi(cfg_depth_hi), .cfg_dither_en(cfg_dither_en),
    .cfg_frm_en(cfg_frm_en), .cfg_frm_slow(cfg_frm_slow),
    .cfg_lo_bus_en(cfg_lo_bus_en), .out_valid(out_valid), .out_panel(out_panel)
  );

  function automatic logic [17:0] model(logic [23:0] rgb, logic x0, logic y0, logic ph);
    logic [17:0] res = '0;
    int n      = cfg_depth_hi ? 4 : 3;
    int maxv   = (1 << n) - 1;
    logic pos  = x0 ^ y0;
    logic dith = cfg_dither_en && !(cfg_depth_hi && cfg_frm_en);
    for (int c = 0; c < 3; c++) begin
      int v   = int'(rgb[c*8 +: 8]);
      int t   = v >> (8 - n);
      int d   = (v >> (7 - n)) & 1;
      int inc = (d == 1 && ((dith && pos) || (cfg_frm_en && (ph ^ pos)))) ? 1 : 0;
      int val = t + inc;
      if (val > maxv) val = maxv;
      res[c*6 +: 6] = 6'(val);
    end
    if (!cfg_lo_bus_en) res[8:0] = '0;
    return res;
  endfunction

  function automatic string tag_of();
    string s = cfg_depth_hi ? "R2" : "R1";
    if (!cfg_dither_en && !cfg_frm_en) s = {s, " R3"};
    if (cfg_frm_en) s = {s, cfg_frm_slow ? " R5 R7" : " R5 R6"};
    if (cfg_dither_en) s = {s, (cfg_depth_hi && cfg_frm_en) ? " R8" : (cfg_frm_en ? " R9" : " R4")};
    if (!cfg_lo_bus_en) s = {s, " R11"};
    s = {s, " R10 R12"};
    return s;
  endfunction

  task automatic check(string tag, logic exp_v, logic [17:0] exp_p);
    checks++;
    if (out_valid !== exp_v || out_panel !== exp_p) begin
      failures++;
      $display("FAIL %s: out_valid=%0b out_panel=%h expected out_valid=%0b out_panel=%h",
               tag, out_valid, out_panel, exp_v, exp_p);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic pixel(logic [23:0] rgb, logic x0, logic y0, logic fs);
    logic [17:0] exp_p;
    in_valid = 1'b1; in_rgb = rgb; in_x0 = x0; in_y0 = y0; frame_start = fs;
    exp_p = model(rgb, x0, y0, m_phase);
    if (fs) begin
      if (!cfg_frm_slow || m_pair) m_phase = ~m_phase;
      m_pair = ~m_pair;
    end
    @(negedge clk);
    check(fs ? {tag_of(), " R6 same-cycle pulse"} : tag_of(), 1'b1, exp_p);
  endtask

  task automatic idle();
    logic [17:0] held = out_panel;
    in_valid = 1'b0; frame_start = 1'b0; in_rgb = 24'hA5C3F0;
    @(negedge clk);
    check("R12 idle hold", 1'b0, held);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_rgb = '0; in_x0 = 1'b0; in_y0 = 1'b0;
    frame_start = 1'b0; cfg_depth_hi = 1'b0; cfg_dither_en = 1'b0;
    cfg_frm_en = 1'b0; cfg_frm_slow = 1'b0; cfg_lo_bus_en = 1'b1;
    m_phase = 1'b0; m_pair = 1'b0;
    repeat (3) @(negedge clk);
    check("R13 reset state", 1'b0, 18'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 after release", 1'b0, 18'h0);

    // R10 directed: all-ones values with dither at every position
    cfg_dither_en = 1'b1; cfg_depth_hi = 1'b1;
    pixel(24'hFFFFFF, 1'b1, 1'b0, 1'b0);
    check("R10 saturate 4-bit", 1'b1, 18'h0F3CF);
    cfg_depth_hi = 1'b0;
    pixel(24'hFFFFFF, 1'b0, 1'b1, 1'b0);
    check("R10 saturate 3-bit", 1'b1, 18'h071C7);
    idle();

    for (int cfg = 0; cfg < 32; cfg++) begin
      cfg_depth_hi  = cfg[0];
      cfg_dither_en = cfg[1];
      cfg_frm_en    = cfg[2];
      cfg_frm_slow  = cfg[3];
      cfg_lo_bus_en = cfg[4];
      for (int fr = 0; fr < 4; fr++) begin
        pixel({8'(fr*37 + cfg), 8'(cfg*11), 8'(fr*90 + 17)}, fr[0], fr[1], 1'b1);
        idle();
        for (int v = 0; v < 256; v++) begin
          logic [1:0] xy = 2'(v + fr);
          pixel({8'(v), 8'(v) ^ 8'h5A, ~8'(v)}, xy[0], xy[1], 1'b0);
        end
      end
    end

    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule